// File: doc/BRIEF.md
# Operand Stack Cache with Background Spill and Fill

This block keeps the topmost words of a processor's operand stack in a 64-slot on-chip array, in place of a conventional register file. The execution datapath pushes, pops and reads the top word through a narrow port. The slots form a ring: the position of the oldest cached word and the occupancy move freely, and every index wraps from the last slot back to the first.

A background engine watches occupancy. When more than 48 words are cached, it writes the oldest cached word out to memory. When fewer than 8 are cached and memory still holds stack words, it reads the most recently spilled word back in below the oldest cached one. It keeps the word address of the in-memory part of the stack, so software never has to issue explicit spill or fill operations. The memory side is a single valid/ready request channel with a separate read-response strobe, and only one transfer is in flight at a time.

The datapath is held off through a busy output only when the cache cannot serve it: a pop with nothing cached, or a push with no free slot.

Top module: `stack_cache`

## Requirements
- R1: After reset the cache holds no words, `top_valid` is low, no memory request is raised, the memory stack pointer is at its base (0), and `busy` is low while neither `push` nor `pop` is asserted.
- R2: Pops return the pushed words in last-in, first-out order. `top_data` shows the most recent word still on the stack whenever `top_valid` is high. A pop takes the word on `top_data` in the same cycle.
- R3: `push` and `pop` asserted together on a non-empty cache replace the top word with `push_data` and leave the occupancy unchanged.
- R4: `busy` rises in the same cycle, and the operation is not performed, when a pop (alone or with a push) meets an empty cache. It also rises when a push alone meets a cache whose occupancy plus any outstanding fill equals 64.
- R5: While the port is idle and the occupancy exceeds 48, the oldest cached word is removed and written (`mem_req_write`=1) at the memory stack pointer, and the pointer then increments. At exactly 48 words no spill is issued.
- R6: While the port is idle, the occupancy is below 8 and the memory stack pointer is above its base, a read is issued at pointer minus one and the pointer decrements. The returned word becomes the new oldest cached word.
- R7: At most one transfer is outstanding. A request stays valid with stable address, data and direction until `mem_req_ready`. No new request is raised while a read response is awaited.
- R8: Last-in, first-out order holds across wrap-around of the ring indices and across any number of spill and fill round trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Push `push_data` onto the stack |
| pop | input | 1 | Pop the top word |
| push_data | input | W | Word to push |
| busy | output | 1 | Requested operation cannot be performed this cycle |
| top_valid | output | 1 | At least one word is cached |
| top_data | output | W | Current top word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = spill write, 0 = fill read |
| mem_req_addr | output | AW | Word address of the transfer |
| mem_req_wdata | output | W | Spilled word |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data returned, at least one cycle after the read is accepted |
| mem_rsp_data | input | W | Returned word |

## Verification
`busy` and `top_data` are combinational, so they are due in the same cycle as the push or pop that asks. The bench drives inputs on the falling edge and samples one nanosecond later, before the edge that commits the operation. A spill request appears one cycle after the occupancy first exceeds 48. A fill request appears one cycle after the occupancy first drops below 8. A filled word becomes visible in the cycle after its response. The bench model follows the logical stack rather than the cache contents, so it does not depend on these delays. Request addresses are checked on each handshake against a pointer the bench steps itself. Hold rules are checked in the sample that follows any cycle in which a request was left waiting.

// File: rtl/stack_cache.sv
module stack_cache #(
  parameter int W       = 32,
  parameter int DEPTH   = 64,
  parameter int HI_MARK = 48,
  parameter int LO_MARK = 8,
  parameter int AW      = 16,
  parameter int SP_BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  push_data,
  output logic          busy,
  output logic          top_valid,
  output logic [W-1:0]  top_data,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [W-1:0]  mem_req_wdata,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [W-1:0]  mem_rsp_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HI_C   = CW'(HI_MARK);
  localparam logic [CW-1:0] LO_C   = CW'(LO_MARK);
  localparam logic [AW-1:0] BASE_C = AW'(SP_BASE);

  logic [W-1:0]  ring [DEPTH];
  logic [PW-1:0] bot;
  logic [CW-1:0] cnt;
  logic [AW-1:0] msp;
  logic          req_v, req_we, rd_wait;
  logic [AW-1:0] req_a;
  logic [W-1:0]  req_d;

  wire port_idle = !req_v && !rd_wait;
  wire spill_go  = port_idle && (cnt > HI_C);
  wire fill_go   = port_idle && !spill_go && (cnt < LO_C) && (msp != BASE_C);
  wire fill_land = rd_wait && mem_rsp_valid;
  wire rd_pend   = rd_wait || (req_v && !req_we);

  wire [CW-1:0] reserved = cnt + CW'(rd_pend);
  assign busy = (pop && cnt == '0) || (push && !pop && reserved >= FULL_C);

  wire do_push = push && !busy;
  wire do_pop  = pop && !busy;

  wire [PW-1:0] top_idx = bot + cnt[PW-1:0] - PW'(1);
  wire [PW-1:0] wr_idx  = do_pop ? top_idx : bot + cnt[PW-1:0];

  assign top_valid = (cnt != '0);
  assign top_data  = ring[top_idx];

  assign mem_req_valid = req_v;
  assign mem_req_write = req_we;
  assign mem_req_addr  = req_a;
  assign mem_req_wdata = req_d;

  wire [CW-1:0] cnt_up = CW'(do_push && !do_pop) + CW'(fill_land);
  wire [CW-1:0] cnt_dn = CW'(do_pop && !do_push) + CW'(spill_go);

  always_ff @(posedge clk) begin
    if (do_push)   ring[wr_idx] <= push_data;
    if (fill_land) ring[bot - PW'(1)] <= mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bot     <= '0;
      cnt     <= '0;
      msp     <= BASE_C;
      req_v   <= 1'b0;
      req_we  <= 1'b0;
      req_a   <= '0;
      req_d   <= '0;
      rd_wait <= 1'b0;
    end else begin
      cnt <= cnt + cnt_up - cnt_dn;
      bot <= bot + PW'(spill_go) - PW'(fill_land);
      if (spill_go) begin
        req_v  <= 1'b1;
        req_we <= 1'b1;
        req_a  <= msp;
        req_d  <= ring[bot];
        msp    <= msp + AW'(1);
      end else if (fill_go) begin
        req_v  <= 1'b1;
        req_we <= 1'b0;
        req_a  <= msp - AW'(1);
        msp    <= msp - AW'(1);
      end else if (req_v && mem_req_ready) begin
        req_v   <= 1'b0;
        rd_wait <= !req_we;
      end else if (fill_land) begin
        rd_wait <= 1'b0;
      end
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_C);

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_v && !mem_req_ready |=> req_v && $stable(req_a) && $stable(req_d) && $stable(req_we));

  a_r7_single_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_v && rd_wait));

  a_r5_spill_above_mark: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_v) && req_we |-> $past(cnt) > HI_C);

  a_r6_fill_below_mark: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_v) && !req_we |-> $past(cnt) < LO_C && $past(msp) != BASE_C);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !req_v && !rd_wait && cnt == '0 && msp == BASE_C);
endmodule

// File: tb/stack_cache_test.sv
`timescale 1ns/1ps
module stack_cache_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [31:0] push_data = '0;
  logic busy, top_valid;
  logic [31:0] top_data;
  logic mreq_v, mreq_we;
  logic [15:0] mreq_a;
  logic [31:0] mreq_d;
  logic mreq_rdy = 1'b0;
  logic mrsp_v = 1'b0;
  logic [31:0] mrsp_d = '0;

  always #2 clk = ~clk;

  stack_cache uut (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .push_data(push_data),
    .busy(busy), .top_valid(top_valid), .top_data(top_data),
    .mem_req_valid(mreq_v), .mem_req_write(mreq_we), .mem_req_addr(mreq_a),
    .mem_req_wdata(mreq_d), .mem_req_ready(mreq_rdy),
    .mem_rsp_valid(mrsp_v), .mem_rsp_data(mrsp_d)
  );

  int checks = 0, errors = 0;
  logic [31:0] stk[$];
  logic [31:0] tbmem [0:1023];
  int exp_sp = 0, rd_delay = -1, nspill = 0, nfill = 0;
  logic [15:0] rd_addr;
  logic hv = 1'b0, h_we;
  logic [15:0] h_a;
  logic [31:0] h_d;
  logic last_busy;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit chance(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic step(input bit ps, input bit pp, input int rdy_pct);
    @(negedge clk);
    push = ps; pop = pp; push_data = $urandom;
    mreq_rdy = chance(rdy_pct);
    if (rd_delay == 0) begin mrsp_v = 1'b1; mrsp_d = tbmem[rd_addr[9:0]]; end
    else mrsp_v = 1'b0;
    #1;
    last_busy = busy;
    if (hv) check(mreq_v && mreq_a == h_a && mreq_d == h_d && mreq_we == h_we,
                  "R7 request held until ready", {16'd0, mreq_a}, {16'd0, h_a});
    if (rd_delay >= 0) check(!mreq_v, "R7 no request while read pending", 32'(mreq_v), 0);
    if (stk.size() == 0) check(!top_valid, "R2 empty stack has no top", 32'(top_valid), 0);
    else if (top_valid) check(top_data == stk[$], "R2 R8 top word order", top_data, stk[$]);
    if (pp && !top_valid) check(busy, "R4 pop on empty stalls", 32'(busy), 1);
    if (!busy) begin
      if (ps && pp) stk[$] = push_data;
      else if (ps) stk.push_back(push_data);
      else if (pp) void'(stk.pop_back());
    end
    if (mrsp_v) rd_delay = -1;
    else if (rd_delay > 0) rd_delay--;
    if (mreq_v && mreq_rdy) begin
      if (mreq_we) begin
        check(mreq_a == 16'(exp_sp), "R5 spill address", {16'd0, mreq_a}, 32'(exp_sp));
        tbmem[mreq_a[9:0]] = mreq_d;
        exp_sp++; nspill++;
      end else begin
        check(mreq_a == 16'(exp_sp - 1), "R6 fill address", {16'd0, mreq_a}, 32'(exp_sp - 1));
        exp_sp--; nfill++;
        rd_addr = mreq_a;
        rd_delay = $urandom % 3;
      end
    end
    hv = mreq_v && !mreq_rdy;
    h_we = mreq_we; h_a = mreq_a; h_d = mreq_d;
  endtask

  initial begin
    int acc;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(!top_valid, "R1 empty after reset", 32'(top_valid), 0);
    check(!mreq_v, "R1 no request after reset", 32'(mreq_v), 0);
    check(!busy, "R1 not busy when idle", 32'(busy), 0);

    step(1'b0, 1'b1, 0);
    check(last_busy, "R4 pop on empty raises busy", 32'(last_busy), 1);

    repeat (48) step(1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 0); step(1'b0, 1'b0, 0);
    check(!mreq_v, "R5 no spill at exactly 48", 32'(mreq_v), 0);

    acc = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 0);
      if (last_busy) break;
      acc++;
    end
    check(acc == 17, "R4 push stalls when full", 32'(acc), 17);
    check(mreq_v && mreq_we && mreq_a == 16'd0 && mreq_d == stk[0],
          "R5 oldest word spilled first", mreq_d, stk[0]);

    step(1'b1, 1'b1, 0);
    v = push_data;
    check(!last_busy, "R3 push with pop on full", 32'(last_busy), 0);
    step(1'b0, 1'b0, 0);
    check(top_data == v, "R3 top replaced", top_data, v);
    step(1'b1, 1'b0, 0);
    check(last_busy, "R3 occupancy unchanged", 32'(last_busy), 1);

    for (int i = 0; i < 1500; i++) step(chance(75), chance(30), 60);
    for (int i = 0; i < 1500; i++) step(chance(30), chance(70), 60);
    for (int i = 0; i < 1500; i++) step(chance(55), chance(50), 40);

    for (int i = 0; i < 4000 && stk.size() > 0; i++) step(1'b0, 1'b1, 100);
    check(stk.size() == 0, "R8 drain completes", 32'(stk.size()), 0);
    repeat (4) step(1'b0, 1'b0, 100);
    check(!top_valid, "R6 all words returned", 32'(top_valid), 0);
    check(exp_sp == 0, "R6 pointer back at base", 32'(exp_sp), 0);
    check(nspill > 0, "R5 spills seen", 32'(nspill), 1);
    check(nfill > 0, "R6 fills seen", 32'(nfill), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule